// File: doc/BRIEF.md
# Dual-Rail Voltage Change Sequencer

The sequencer applies one voltage change to a core supply while keeping a dependent memory supply at or above a safe minimum. A request carries the new core voltage, a performance corner index and a direction code. From these the block works out the memory-rail minimum under a selectable policy. It then drives two rail-controller ports in the order that never leaves the memory rail below what the core needs. When rising, the memory rail moves first. When falling, the core rail moves first. A single `done` or `error` pulse ends the sequence.

Each rail controller sits behind a request port. The port carries a valid/ready request with a voltage and an upper bound, and answers with a one-cycle response pulse that has an error flag. The block holds the requested value and the valid until ready is seen; it applies back-pressure by keeping the request stable for any number of cycles. A response that does not come within `TIMEOUT` cycles of the start of a write counts as a failure. On the request side, `req_ready` is low for as long as a sequence runs.

Top module: `rail_seq`

## Requirements
- R1: With direction 1 (raise), a memory-rail write that is needed is accepted on its port before the core-rail write.
- R2: With direction 2 (lower), the core-rail write is accepted first and a needed memory-rail write follows it.
- R3: A memory-rail write happens only when the direction is raise or lower, the computed minimum is nonzero, and the minimum differs from `mem_applied`. Direction 0 or 3 never writes the memory rail.
- R4: The 3-bit `mem_method` picks the memory minimum: 0 = the requested core voltage; 1 = the ceiling of the requested corner (slice `corner*VW` of `corner_ceil`); 2 = `slow_turbo_ceil`; 3 = `mem_vmax`; 4 to 7 = zero, which causes no memory write.
- R5: With `mem_present` low, the direction is treated as 0 and only the core rail is written.
- R6: A failed first write ends the sequence with an `error` pulse, and the second write is never issued. A failure of the second write also ends in `error`.
- R7: `mem_applied` resets to 0. It takes the new minimum only after the memory port responds with no error.
- R8: Every core write carries `ceil_max` on `core_max`. Every memory write carries `mem_vmax` on `mem_max`.
- R9: `req_ready` is high exactly when the block is idle. `busy` rises on the cycle after a request is accepted and falls on the same edge that raises `done` or `error`.
- R10: A port keeps valid high and its voltage stable until ready. A response with the error bit set, or no response within `TIMEOUT` cycles of the write's start, is a failure.
- R11: `done` and `error` never pulse together. `done` follows only when every write issued has succeeded, and exactly one core write is made per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Change request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_volt | input | VW | New core voltage |
| req_corner | input | CW | Performance corner index |
| req_dir | input | 2 | 0 none, 1 raise, 2 lower, 3 none |
| mem_present | input | 1 | Memory rail exists |
| mem_method | input | 3 | Memory-minimum policy |
| corner_ceil | input | NCORNER*VW | Per-corner ceiling voltages, corner 0 in low bits |
| slow_turbo_ceil | input | VW | Top-corner ceiling of the slowest process bin |
| mem_vmax | input | VW | Fixed memory-rail maximum |
| ceil_max | input | VW | Global core ceiling |
| core_valid | output | 1 | Core write request |
| core_ready | input | 1 | Core controller takes request |
| core_volt | output | VW | Core target voltage |
| core_max | output | VW | Core upper bound |
| core_rsp | input | 1 | Core response pulse |
| core_err | input | 1 | Core response failed |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory controller takes request |
| mem_volt | output | VW | Memory target voltage |
| mem_max | output | VW | Memory upper bound |
| mem_rsp | input | 1 | Memory response pulse |
| mem_err | input | 1 | Memory response failed |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence succeeded (pulse) |
| error | output | 1 | Sequence failed (pulse) |
| mem_applied | output | VW | Last memory minimum applied successfully |

## Verification
The assertions check properties on every cycle:
- the two rail ports are never requested together;
- a stalled port holds its voltage;
- `done` and `error` are exclusive;
- `busy` follows acceptance and falls only with an end pulse;
- `mem_applied` moves only two cycles after a clean memory response.

Only the bench scenarios can show the rest. These cover the write order for each direction, the policy values, the skip of an unchanged minimum, the abort after a failed or timed-out first write, and the bounds that are carried with each write.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  localparam logic [1:0] DIR_NONE = 2'd0;
  localparam logic [1:0] DIR_UP   = 2'd1;
  localparam logic [1:0] DIR_DOWN = 2'd2;

  localparam logic [2:0] MSEL_CORE    = 3'd0;
  localparam logic [2:0] MSEL_CORNER  = 3'd1;
  localparam logic [2:0] MSEL_SLOWTOP = 3'd2;
  localparam logic [2:0] MSEL_MEMMAX  = 3'd3;

  typedef enum logic [1:0] {
    S_IDLE      = 2'd0,
    S_MEM_FIRST = 2'd1,
    S_CORE      = 2'd2,
    S_MEM_LAST  = 2'd3
  } seq_e;

  typedef enum logic [1:0] {
    P_IDLE = 2'd0,
    P_REQ  = 2'd1,
    P_WAIT = 2'd2
  } port_e;
endpackage

// File: rtl/rail_mem_target.sv
module rail_mem_target
  import rail_seq_pkg::*;
#(
  parameter int VW      = 12,
  parameter int NCORNER = 3,
  parameter int CW      = 2
) (
  input  logic [2:0]            method,
  input  logic [VW-1:0]         new_volt,
  input  logic [CW-1:0]         corner,
  input  logic [NCORNER*VW-1:0] corner_ceil,
  input  logic [VW-1:0]         slow_top,
  input  logic [VW-1:0]         mem_vmax,
  output logic [VW-1:0]         target
);
  logic [VW-1:0] ceil_arr [NCORNER];
  logic [VW-1:0] ceil_sel;

  for (genvar g = 0; g < NCORNER; g++) begin : g_unpack
    assign ceil_arr[g] = corner_ceil[g*VW +: VW];
  end

  always_comb begin
    ceil_sel = '0;
    for (int i = 0; i < NCORNER; i++)
      if (corner == CW'(i)) ceil_sel = ceil_arr[i];
  end

  always_comb begin
    case (method)
      MSEL_CORE:    target = new_volt;
      MSEL_CORNER:  target = ceil_sel;
      MSEL_SLOWTOP: target = slow_top;
      MSEL_MEMMAX:  target = mem_vmax;
      default:      target = '0;
    endcase
  end
endmodule

// File: rtl/rail_port.sv
module rail_port
  import rail_seq_pkg::*;
#(
  parameter int VW      = 12,
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] volt_in,
  output logic          valid,
  output logic [VW-1:0] volt,
  input  logic          ready,
  input  logic          rsp,
  input  logic          err,
  output logic          fin,
  output logic          fail
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

  port_e         st;
  logic [TW-1:0] cnt;

  assign valid = (st == P_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= P_IDLE;
      cnt  <= '0;
      volt <= '0;
      fin  <= 1'b0;
      fail <= 1'b0;
    end else begin
      fin  <= 1'b0;
      fail <= 1'b0;
      case (st)
        P_IDLE: if (start) begin
          st   <= P_REQ;
          cnt  <= '0;
          volt <= volt_in;
        end
        P_REQ: begin
          if (ready) begin
            st  <= P_WAIT;
            cnt <= cnt + 1'b1;
          end else if (cnt == LAST) begin
            st   <= P_IDLE;
            fin  <= 1'b1;
            fail <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        P_WAIT: begin
          if (rsp) begin
            st   <= P_IDLE;
            fin  <= 1'b1;
            fail <= err;
          end else if (cnt >= LAST) begin
            st   <= P_IDLE;
            fin  <= 1'b1;
            fail <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  // R10: a stalled request keeps valid and its voltage until ready or timeout
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && cnt != LAST) |=> (valid && $stable(volt)));

  // R10: completion is reported only from an idle-returning port
  a_r10_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !valid);
endmodule

// File: rtl/rail_seq.sv
module rail_seq
  import rail_seq_pkg::*;
#(
  parameter int VW      = 12,
  parameter int NCORNER = 3,
  parameter int CW      = 2,
  parameter int TIMEOUT = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VW-1:0]         req_volt,
  input  logic [CW-1:0]         req_corner,
  input  logic [1:0]            req_dir,
  input  logic                  mem_present,
  input  logic [2:0]            mem_method,
  input  logic [NCORNER*VW-1:0] corner_ceil,
  input  logic [VW-1:0]         slow_turbo_ceil,
  input  logic [VW-1:0]         mem_vmax,
  input  logic [VW-1:0]         ceil_max,
  output logic                  core_valid,
  input  logic                  core_ready,
  output logic [VW-1:0]         core_volt,
  output logic [VW-1:0]         core_max,
  input  logic                  core_rsp,
  input  logic                  core_err,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [VW-1:0]         mem_volt,
  output logic [VW-1:0]         mem_max,
  input  logic                  mem_rsp,
  input  logic                  mem_err,
  output logic                  busy,
  output logic                  done,
  output logic                  error,
  output logic [VW-1:0]         mem_applied
);
  seq_e          st;
  logic [VW-1:0] volt_q, tgt_q, tgt_c;
  logic          last_mem_q;
  logic          start_core, start_mem;
  logic          core_fin, core_fail, mem_fin, mem_fail;
  logic [1:0]    dir_eff;
  logic          need_mem;

  assign req_ready = (st == S_IDLE);
  assign busy      = !req_ready;
  assign core_max  = ceil_max;
  assign mem_max   = mem_vmax;

  rail_mem_target #(.VW(VW), .NCORNER(NCORNER), .CW(CW)) u_target (
    .method(mem_method), .new_volt(req_volt), .corner(req_corner),
    .corner_ceil(corner_ceil), .slow_top(slow_turbo_ceil),
    .mem_vmax(mem_vmax), .target(tgt_c)
  );

  always_comb begin
    if (!mem_present || req_dir == 2'd3) dir_eff = DIR_NONE;
    else                                 dir_eff = req_dir;
    need_mem = (dir_eff != DIR_NONE) && (tgt_c != '0) && (tgt_c != mem_applied);
  end

  rail_port #(.VW(VW), .TIMEOUT(TIMEOUT)) u_core_port (
    .clk(clk), .rst_n(rst_n), .start(start_core), .volt_in(volt_q),
    .valid(core_valid), .volt(core_volt), .ready(core_ready),
    .rsp(core_rsp), .err(core_err), .fin(core_fin), .fail(core_fail)
  );

  rail_port #(.VW(VW), .TIMEOUT(TIMEOUT)) u_mem_port (
    .clk(clk), .rst_n(rst_n), .start(start_mem), .volt_in(tgt_q),
    .valid(mem_valid), .volt(mem_volt), .ready(mem_ready),
    .rsp(mem_rsp), .err(mem_err), .fin(mem_fin), .fail(mem_fail)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      volt_q      <= '0;
      tgt_q       <= '0;
      last_mem_q  <= 1'b0;
      start_core  <= 1'b0;
      start_mem   <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
      mem_applied <= '0;
    end else begin
      start_core <= 1'b0;
      start_mem  <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          volt_q     <= req_volt;
          tgt_q      <= tgt_c;
          last_mem_q <= need_mem && (dir_eff == DIR_DOWN);
          if (need_mem && dir_eff == DIR_UP) begin
            st        <= S_MEM_FIRST;
            start_mem <= 1'b1;
          end else begin
            st         <= S_CORE;
            start_core <= 1'b1;
          end
        end
        S_MEM_FIRST: if (mem_fin) begin
          if (mem_fail) begin
            st    <= S_IDLE;
            error <= 1'b1;
          end else begin
            mem_applied <= tgt_q;
            st          <= S_CORE;
            start_core  <= 1'b1;
          end
        end
        S_CORE: if (core_fin) begin
          if (core_fail) begin
            st    <= S_IDLE;
            error <= 1'b1;
          end else if (last_mem_q) begin
            st        <= S_MEM_LAST;
            start_mem <= 1'b1;
          end else begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_MEM_LAST: if (mem_fin) begin
          st <= S_IDLE;
          if (mem_fail) error <= 1'b1;
          else begin
            mem_applied <= tgt_q;
            done        <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: the two rails are never requested in the same cycle
  a_r1_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_valid && mem_valid));

  // R11: success and failure pulses are exclusive
  a_r11_exclusive_end: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R9: an accepted request makes the block busy on the next cycle
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R9: busy ends only together with an end pulse
  a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || error));

  // R7: recorded minimum moves only after a clean memory response
  a_r7_applied_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_applied) |-> $past(mem_rsp && !mem_err, 2));
endmodule

// File: tb/rail_seq_bench.sv
module rail_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 12;
  localparam int NCORNER = 3;
  localparam int CW = 2;
  localparam int TIMEOUT = 16;
  localparam int CEIL0 = 900, CEIL1 = 1000, CEIL2 = 1100;
  localparam int SLOWTOP = 1150, MEMVMAX = 1200, CEILMAX = 1250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [VW-1:0] req_volt = '0;
  logic [CW-1:0] req_corner = '0;
  logic [1:0] req_dir = '0;
  logic mem_present = 1'b1;
  logic [2:0] mem_method = '0;
  logic [NCORNER*VW-1:0] corner_ceil;
  logic [VW-1:0] slow_turbo_ceil, mem_vmax, ceil_max;
  logic core_valid, core_ready = 1'b1, core_rsp = 1'b0, core_err = 1'b0;
  logic mem_valid, mem_ready = 1'b1, mem_rsp = 1'b0, mem_err = 1'b0;
  logic [VW-1:0] core_volt, core_max, mem_volt, mem_max, mem_applied;
  logic busy, done, error;

  assign corner_ceil = {VW'(CEIL2), VW'(CEIL1), VW'(CEIL0)};
  assign slow_turbo_ceil = VW'(SLOWTOP);
  assign mem_vmax = VW'(MEMVMAX);
  assign ceil_max = VW'(CEILMAX);

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_seq #(.VW(VW), .NCORNER(NCORNER), .CW(CW), .TIMEOUT(TIMEOUT)) u_rail_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_volt(req_volt), .req_corner(req_corner), .req_dir(req_dir),
    .mem_present(mem_present), .mem_method(mem_method), .corner_ceil(corner_ceil),
    .slow_turbo_ceil(slow_turbo_ceil), .mem_vmax(mem_vmax), .ceil_max(ceil_max),
    .core_valid(core_valid), .core_ready(core_ready), .core_volt(core_volt),
    .core_max(core_max), .core_rsp(core_rsp), .core_err(core_err),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_volt(mem_volt),
    .mem_max(mem_max), .mem_rsp(mem_rsp), .mem_err(mem_err),
    .busy(busy), .done(done), .error(error), .mem_applied(mem_applied)
  );

  int n_chk = 0, n_fail = 0;
  // rail models
  int core_fail_k = 0, mem_fail_k = 0, core_mute = 0, mem_mute = 0;
  int core_stall = 0, mem_stall = 0;
  bit core_pend = 0, mem_pend = 0;
  int ord = 0, core_n = 0, mem_n = 0, core_ord = 0, mem_ord = 0;
  int core_v = 0, core_m = 0, mem_v = 0, mem_m = 0;
  int applied_m = 0;
  bit res_done, res_err;

  always @(negedge clk) begin
    core_rsp = 1'b0; core_err = 1'b0;
    if (core_pend) begin
      core_pend = 0;
      if (core_mute == 0) begin core_rsp = 1'b1; core_err = (core_fail_k != 0); end
    end
    if (core_valid && core_stall > 0) core_stall--;
    core_ready = (core_stall == 0);
    if (core_valid && core_ready) begin
      core_pend = 1; core_n++; ord++; core_ord = ord;
      core_v = int'(core_volt); core_m = int'(core_max);
    end
    mem_rsp = 1'b0; mem_err = 1'b0;
    if (mem_pend) begin
      mem_pend = 0;
      if (mem_mute == 0) begin mem_rsp = 1'b1; mem_err = (mem_fail_k != 0); end
    end
    if (mem_valid && mem_stall > 0) mem_stall--;
    mem_ready = (mem_stall == 0);
    if (mem_valid && mem_ready) begin
      mem_pend = 1; mem_n++; ord++; mem_ord = ord;
      mem_v = int'(mem_volt); mem_m = int'(mem_max);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input int volt, input int corner, input int dir);
    ord = 0; core_n = 0; mem_n = 0; core_ord = 0; mem_ord = 0;
    @(negedge clk);
    req_valid = 1'b1; req_volt = VW'(volt); req_corner = CW'(corner); req_dir = 2'(dir);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy after accept", int'(busy), 1);
    chk("R9 ready low while busy", int'(req_ready), 0);
    res_done = 0; res_err = 0;
    for (int i = 0; i < 200; i++) begin
      if (done || error) break;
      @(negedge clk);
    end
    res_done = done; res_err = error;
    if (!res_done && !res_err) chk("R11 sequence ended", 0, 1);
    @(negedge clk);
    chk("R9 idle after end", int'(req_ready), 1);
  endtask

  function automatic int exp_tgt(input int method, input int volt, input int corner);
    case (method)
      0: return volt;
      1: return (corner == 0) ? CEIL0 : (corner == 1) ? CEIL1 : CEIL2;
      2: return SLOWTOP;
      3: return MEMVMAX;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset busy", int'(busy), 0);
    chk("R9 reset ready", int'(req_ready), 1);
    chk("R7 reset applied", int'(mem_applied), 0);
    chk("R10 reset core_valid", int'(core_valid), 0);
    chk("R10 reset mem_valid", int'(mem_valid), 0);

    // Sweep: presence x method x direction x corner
    for (int p = 1; p >= 0; p--) begin
      for (int m = 0; m < 8; m++) begin
        for (int d = 0; d < 4; d++) begin
          for (int c = 0; c < NCORNER; c++) begin
            int v, de, t, need;
            v = 700 + 7 * (m * 12 + d * 3 + c);
            mem_present = p[0]; mem_method = 3'(m);
            de = (p == 0 || d == 3) ? 0 : d;
            t = exp_tgt(m, v, c);
            need = (de != 0 && t != 0 && t != applied_m) ? 1 : 0;
            do_req(v, c, d);
            chk("R11 done", int'(res_done), 1);
            chk("R5 one core write", core_n, 1);
            chk("R11 core voltage", core_v, v);
            chk("R8 core bound", core_m, CEILMAX);
            chk("R3 R4 R5 memory write count", mem_n, need);
            if (need != 0) begin
              chk("R4 memory minimum", mem_v, t);
              chk("R8 memory bound", mem_m, MEMVMAX);
              if (de == 1) chk("R1 memory before core", int'(mem_ord < core_ord), 1);
              else         chk("R2 core before memory", int'(core_ord < mem_ord), 1);
              applied_m = t;
            end
            chk("R7 applied", int'(mem_applied), applied_m);
          end
        end
      end
    end

    mem_present = 1'b1; mem_method = 3'd0;
    // R6: failed first memory write on raise aborts
    mem_fail_k = 1;
    do_req(1300, 0, 1);
    chk("R6 error on first failure", int'(res_err), 1);
    chk("R6 core not written", core_n, 0);
    chk("R7 applied kept after failure", int'(mem_applied), applied_m);
    mem_fail_k = 0;
    // R6: failed first core write on lower aborts
    core_fail_k = 1;
    do_req(1310, 1, 2);
    chk("R6 error core first", int'(res_err), 1);
    chk("R6 memory not written", mem_n, 0);
    // R7: memory succeeds then core fails on raise
    do_req(1320, 1, 1);
    chk("R6 error second write", int'(res_err), 1);
    chk("R7 applied after clean memory ack", int'(mem_applied), 1320);
    applied_m = 1320;
    core_fail_k = 0;
    // R7: failed last memory write on lower
    mem_fail_k = 1;
    do_req(1330, 2, 2);
    chk("R6 error on last write", int'(res_err), 1);
    chk("R2 core written first", core_n, 1);
    chk("R7 applied kept", int'(mem_applied), applied_m);
    mem_fail_k = 0;
    // R10: core response never comes
    core_mute = 1;
    do_req(1000, 0, 0);
    chk("R10 timeout error", int'(res_err), 1);
    core_mute = 0;
    // R10: stalled ready still completes with stable value
    core_stall = 4;
    do_req(1111, 2, 0);
    chk("R10 stalled done", int'(res_done), 1);
    chk("R10 stalled voltage", core_v, 1111);
    // R10: memory port never ready -> timeout, core not written
    mem_stall = TIMEOUT + 5;
    do_req(1340, 0, 1);
    chk("R10 request timeout error", int'(res_err), 1);
    chk("R6 core skipped after timeout", core_n, 0);
    mem_stall = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule